// File: doc/BRIEF.md
# Chip-Select Gated Synchronous Serial Port

This block is an 8-bit synchronous serial channel for a small controller. It has a shift clock, a serial output and a serial input, plus an active-low chip-select input. The host side writes a byte to start a transfer. It reads the received byte when the done flag rises, and it gets a one-cycle interrupt pulse at the same time. The shift clock comes from one of two sources. An internal divider can generate it, with high and low phases of `HALF_DIV` system clocks each. A remote master can drive it instead, through `sck_in`.

In chip-select mode, the output enables for the clock pad and the data pad follow the synchronized chip-select level. The pads drive only while chip-select is low, and they float again once it rises. If chip-select rises in the middle of a byte, the transfer is abandoned. Data is shifted most significant bit first. Output data changes after a falling shift-clock edge, and input data is taken on the rising edge. Every pin input passes through a two-flop synchronizer before the block uses it.

Top module: `csg_spi_port`

## Requirements
- R1: During synchronous reset the outputs are `sck_out`=1, `sdo`=0, `sck_oe`=0, `sdo_oe`=0, `done`=0, `irq`=0, `overrun`=0 and `rx_data`=0.
- R2: With the internal clock (`cfg_ext_clk`=0), `sck_out` idles high. It goes low in the cycle after an accepted write. Each low phase and each high phase lasts `HALF_DIV` system clocks, so one rising edge follows the next after 2*`HALF_DIV` clocks.
- R3: `sdo` shows bit 7 of the written byte as soon as the write is accepted. After each falling shift-clock edge that follows a rising edge, `sdo` moves to the next lower bit, so the byte leaves most significant bit first.
- R4: `sdi` is taken after a two-flop synchronizer at every rising shift-clock edge and fills the receive byte MSB first. `rx_data` changes only when a byte completes.
- R5: In the cycle that the eighth rising edge is registered, `done` goes to 1 and `irq` pulses high for exactly one cycle. `done` stays at 1 until the next accepted write clears it.
- R6: With the external clock (`cfg_ext_clk`=1), `sck_oe` stays 0. Rising edges of `sck_in`, after two synchronizer flops, sample the input and falling edges shift the output. Eight rising edges complete the byte.
- R7: With `cfg_cs_mode`=0, `sdo_oe`=1 and `sck_oe`=1 (internal clock only). With `cfg_cs_mode`=1, both enables are 1 only while `cs_n` is low, and each follows a change of `cs_n` on the third clock edge.
- R8: In chip-select mode, the internal shift clock and the bit sequence are frozen while `cs_n` is high. A byte written while `cs_n` is high waits until `cs_n` goes low.
- R9: In chip-select mode, a rise of `cs_n` during a transfer ends it. `done` and `irq` stay 0, `rx_data` keeps its previous value and `sck_out` returns high. The next written byte starts again from its MSB.
- R10: A write while a transfer is in progress is ignored and sets `overrun`. The next accepted write clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ext_clk | input | 1 | 1 selects the external shift clock, 0 the internal divider |
| cfg_cs_mode | input | 1 | 1 gates the pad drivers and the transfer with chip-select |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | DATA_W | Transmit byte |
| rx_data | output | DATA_W | Last completely received byte |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |
| overrun | output | 1 | Set by a write during a transfer |
| cs_n | input | 1 | Active-low chip-select pin |
| sck_in | input | 1 | External shift clock pin input |
| sck_out | output | 1 | Internally generated shift clock |
| sck_oe | output | 1 | Drive enable for the clock pad |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Drive enable for the data pad |

## Verification
Each transfer uses its own transmit byte and its own receive pattern: A5/3C, 5A/C3, 0F/F0, 96/69, 3C/A1 and 4B/B4. Together they have alternating, clustered and inverted bits, so a swapped bit order, an off-by-one shift or a missing sample gives a different byte. Both clock sources are exercised. A chip-select phase that is held high shows whether the clock truly pauses, and a chip-select rise after three bits shows whether the abort works. A write made in the middle of a byte separates a correct ignore from a corrupted shift register. A behavioural model compares every output on every cycle, so phase lengths and enable timing are checked as closely as the final bytes.

// File: rtl/csg_spi_pkg.sv
package csg_spi_pkg;
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } sck_src_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } sck_edge_t;
endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/csg_sck_gen.sv
module csg_sck_gen
  import csg_spi_pkg::*;
#(
  parameter int HALF_DIV = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      restart,
  input  logic      park,
  input  logic      run,
  output logic      sck,
  output sck_edge_t edge_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             wrap;

  assign wrap        = run && (div_q == LAST);
  assign edge_o.rise = wrap && !sck;
  assign edge_o.fall = wrap && sck;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      sck   <= 1'b1;
    end else if (restart) begin
      div_q <= '0;
      sck   <= 1'b0;
    end else if (park) begin
      div_q <= '0;
      sck   <= 1'b1;
    end else if (run) begin
      if (div_q == LAST) begin
        div_q <= '0;
        sck   <= ~sck;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  AST_SCK_HOLD_PAUSED: assert property (@(posedge clk) disable iff (rst)
    (!restart && !park && !run) |=> $stable(sck)); // R8
endmodule

// File: rtl/csg_shift_core.sv
module csg_shift_core
  import csg_spi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  sck_src_e          src,
  input  logic              cs_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  sck_edge_t         int_edge,
  output logic              busy,
  output logic              run_ok,
  output logic              abort,
  output logic              sdo,
  output logic              sck_oe,
  output logic              sdo_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              irq,
  output logic              overrun
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              cs_q, sck_q;
  logic              cs_low, cs_rise, ext_rise, ext_fall;
  logic              ev_rise, ev_fall, accept;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-2:0] rxs_q;
  logic [DATA_W-1:0] rx_next;

  assign cs_low   = !cs_s;
  assign cs_rise  = cs_s && !cs_q;
  assign run_ok   = !cs_mode || cs_low;
  assign ext_rise = sck_s && !sck_q;
  assign ext_fall = !sck_s && sck_q;
  assign accept   = wr_en && !busy;
  assign abort    = cs_mode && cs_rise && busy;
  assign rx_next  = {rxs_q, sdi_s};
  assign sdo      = tx_q[DATA_W-1];

  always_comb begin
    if (src == SRC_EXTERNAL) begin
      ev_rise = busy && run_ok && ext_rise;
      ev_fall = busy && run_ok && ext_fall;
    end else begin
      ev_rise = int_edge.rise;
      ev_fall = int_edge.fall;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b1;
      sck_q   <= 1'b1;
      busy    <= 1'b0;
      bit_q   <= '0;
      tx_q    <= '0;
      rxs_q   <= '0;
      rx_data <= '0;
      done    <= 1'b0;
      irq     <= 1'b0;
      overrun <= 1'b0;
      sck_oe  <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sck_q  <= sck_s;
      irq    <= 1'b0;
      sck_oe <= (src == SRC_INTERNAL) && run_ok;
      sdo_oe <= run_ok;
      if (accept) begin
        busy    <= 1'b1;
        tx_q    <= wr_data;
        bit_q   <= '0;
        done    <= 1'b0;
        overrun <= 1'b0;
      end else begin
        if (wr_en) overrun <= 1'b1;
        if (abort) begin
          busy  <= 1'b0;
          bit_q <= '0;
        end else if (ev_rise) begin
          rxs_q <= rx_next[DATA_W-2:0];
          if (bit_q == LAST_BIT) begin
            bit_q   <= '0;
            busy    <= 1'b0;
            done    <= 1'b1;
            irq     <= 1'b1;
            rx_data <= rx_next;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end else if (ev_fall && (bit_q != '0)) begin
          tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R5
  AST_OVR_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> overrun); // R10
  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!done && !irq)); // R9
  AST_OE_FLOAT_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cs_mode && cs_s) |=> (!sdo_oe && !sck_oe)); // R7
endmodule

// File: rtl/csg_spi_port.sv
module csg_spi_port
  import csg_spi_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ext_clk,
  input  logic              cfg_cs_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic              irq,
  output logic              overrun,
  input  logic              cs_n,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int SYNC_W = 3;

  sck_src_e          src;
  logic [SYNC_W-1:0] pins_s;
  sck_edge_t         int_edge;
  logic              busy, run_ok, abort, restart, run;

  assign src = sck_src_e'(cfg_ext_clk);

  csg_sync #(
    .W       (SYNC_W),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sck_in, sdi}),
    .q   (pins_s)
  );

  assign restart = wr_en && !busy && (src == SRC_INTERNAL);
  assign run     = busy && run_ok && (src == SRC_INTERNAL);

  csg_sck_gen #(
    .HALF_DIV (HALF_DIV)
  ) u_sck_gen (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .park    (abort),
    .run     (run),
    .sck     (sck_out),
    .edge_o  (int_edge)
  );

  csg_shift_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .src      (src),
    .cs_mode  (cfg_cs_mode),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cs_s     (pins_s[2]),
    .sck_s    (pins_s[1]),
    .sdi_s    (pins_s[0]),
    .int_edge (int_edge),
    .busy     (busy),
    .run_ok   (run_ok),
    .abort    (abort),
    .sdo      (sdo),
    .sck_oe   (sck_oe),
    .sdo_oe   (sdo_oe),
    .rx_data  (rx_data),
    .done     (done),
    .irq      (irq),
    .overrun  (overrun)
  );
endmodule

// File: tb/test_csg_spi_port.sv
module test_csg_spi_port;
  localparam int DW   = 8;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic cfg_ext_clk = 1'b0, cfg_cs_mode = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic cs_n = 1'b1, sck_in = 1'b1, sdi = 1'b0;
  logic [DW-1:0] rx_data;
  logic done, irq, overrun, sck_out, sck_oe, sdo, sdo_oe;

  csg_spi_port #(.DATA_W(DW), .HALF_DIV(HALF)) i_csg_spi_port (
    .clk(clk), .rst(rst), .cfg_ext_clk(cfg_ext_clk), .cfg_cs_mode(cfg_cs_mode),
    .wr_en(wr_en), .wr_data(wr_data), .rx_data(rx_data), .done(done), .irq(irq),
    .overrun(overrun), .cs_n(cs_n), .sck_in(sck_in), .sck_out(sck_out),
    .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe));

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // behavioural reference, advanced once per clock
  bit m_c1, m_c2, m_c3, m_k1, m_k2, m_k3, m_d1, m_d2;
  bit m_busy, m_sck, m_sckoe, m_sdooe, m_done, m_irq, m_ovr;
  int m_div, m_bits;
  bit [7:0] m_tx, m_rxs, m_rx;
  bit t_cslo, t_run, t_wrap, t_er, t_ef, t_abort;
  bit [7:0] t_nx;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_c1 = 1; m_c2 = 1; m_c3 = 1; m_k1 = 1; m_k2 = 1; m_k3 = 1; m_d1 = 0; m_d2 = 0;
      m_busy = 0; m_sck = 1; m_sckoe = 0; m_sdooe = 0; m_done = 0; m_irq = 0; m_ovr = 0;
      m_div = 0; m_bits = 0; m_tx = 0; m_rxs = 0; m_rx = 0;
    end else begin
      t_cslo  = !m_c2;
      t_run   = m_busy && (!cfg_cs_mode || t_cslo);
      t_wrap  = (m_div == HALF - 1);
      if (cfg_ext_clk) begin
        t_er = t_run && m_k2 && !m_k3;
        t_ef = t_run && !m_k2 && m_k3;
      end else begin
        t_er = t_run && t_wrap && !m_sck;
        t_ef = t_run && t_wrap && m_sck;
      end
      t_abort = cfg_cs_mode && m_c2 && !m_c3 && m_busy;
      m_irq = 0;
      if (!cfg_ext_clk && wr_en && !m_busy) begin m_sck = 0; m_div = 0; end
      else if (t_abort) begin m_sck = 1; m_div = 0; end
      else if (!cfg_ext_clk && t_run) begin
        if (t_wrap) begin m_div = 0; m_sck = !m_sck; end else m_div++;
      end
      if (wr_en && !m_busy) begin
        m_busy = 1; m_tx = wr_data; m_bits = 0; m_done = 0; m_ovr = 0;
      end else begin
        if (wr_en) m_ovr = 1;
        if (t_abort) begin m_busy = 0; m_bits = 0; end
        else if (t_er) begin
          t_nx = {m_rxs[6:0], m_d2};
          m_rxs = t_nx;
          if (m_bits == 7) begin
            m_bits = 0; m_busy = 0; m_done = 1; m_irq = 1; m_rx = t_nx;
          end else m_bits++;
        end else if (t_ef && m_bits != 0) m_tx = m_tx << 1;
      end
      m_sckoe = !cfg_ext_clk && (!cfg_cs_mode || t_cslo);
      m_sdooe = !cfg_cs_mode || t_cslo;
      m_c3 = m_c2; m_c2 = m_c1; m_c1 = cs_n;
      m_k3 = m_k2; m_k2 = m_k1; m_k1 = sck_in;
      m_d2 = m_d1; m_d1 = sdi;
    end
    if (cyc > 100000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (cyc > 0 && !finished) begin
      chk("R2", "sck_out", sck_out, m_sck);
      chk("R3", "sdo", sdo, m_tx[7]);
      chk("R7", "sck_oe", sck_oe, m_sckoe);
      chk("R7", "sdo_oe", sdo_oe, m_sdooe);
      chk("R5", "done", done, m_done);
      chk("R5", "irq", irq, m_irq);
      chk("R10", "overrun", overrun, m_ovr);
      chk("R4", "rx_data", rx_data, m_rx);
    end
  end

  task automatic write_byte(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_rises(input logic [7:0] pat, input int stop_at, input int ovr_at,
                           output logic [7:0] cap, output int t1, output int t2);
    int n = 0;
    int guard = 0;
    logic prev;
    cap = '0; t1 = 0; t2 = 0;
    sdi = pat[7];
    prev = sck_out;
    while (n < stop_at && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (wr_en) wr_en = 1'b0;
      if (sck_out && !prev) begin
        cap = {cap[6:0], sdo};
        n++;
        if (n == 1) t1 = cyc;
        if (n == 2) t2 = cyc;
        if (n < 8) sdi = pat[7-n];
        if (n == ovr_at) begin wr_en = 1'b1; wr_data = 8'hFF; end
      end
      prev = sck_out;
    end
  endtask

  initial begin
    logic [7:0] cap;
    int t0, t1, t2, moves;
    repeat (3) @(negedge clk);
    chk("R1", "reset sck_out", sck_out, 1);
    chk("R1", "reset sdo", sdo, 0);
    chk("R1", "reset sck_oe", sck_oe, 0);
    chk("R1", "reset sdo_oe", sdo_oe, 0);
    chk("R1", "reset done/irq/overrun", {done, irq, overrun}, 0);
    chk("R1", "reset rx_data", rx_data, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // internal clock, no chip-select gating
    write_byte(8'hA5);
    t0 = cyc;
    chk("R2", "sck low after write", sck_out, 0);
    run_rises(8'h3C, 8, 0, cap, t1, t2);
    chk("R2", "low phase length", t1 - t0, HALF);
    chk("R2", "rise to rise", t2 - t1, 2 * HALF);
    chk("R3", "sent bits", cap, 8'hA5);
    chk("R4", "received byte", rx_data, 8'h3C);
    chk("R5", "done at 8th rise", {done, irq}, 2'b11);
    @(negedge clk);
    chk("R5", "irq single, done held", {done, irq}, 2'b10);

    // overrun: write in the middle of a byte
    repeat (3) @(negedge clk);
    write_byte(8'h5A);
    run_rises(8'hC3, 8, 3, cap, t1, t2);
    chk("R10", "overrun set", overrun, 1);
    chk("R10", "mid-byte write ignored", cap, 8'h5A);
    chk("R4", "received byte 2", rx_data, 8'hC3);
    repeat (3) @(negedge clk);
    write_byte(8'h0F);
    chk("R10", "overrun cleared", overrun, 0);
    chk("R5", "done cleared", done, 0);
    run_rises(8'hF0, 8, 0, cap, t1, t2);
    chk("R3", "sent bits 3", cap, 8'h0F);
    chk("R4", "received byte 3", rx_data, 8'hF0);

    // external clock
    repeat (3) @(negedge clk);
    cfg_ext_clk = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6", "sck_oe off", sck_oe, 0);
    write_byte(8'h96);
    cap = '0;
    for (int i = 0; i < 8; i++) begin
      sck_in = 1'b0; sdi = 8'h69 >> (7 - i);
      repeat (4) @(negedge clk);
      cap = {cap[6:0], sdo};
      sck_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    chk("R6", "ext sent bits", cap, 8'h96);
    chk("R6", "ext received", rx_data, 8'h69);
    chk("R6", "ext done", done, 1);
    cfg_ext_clk = 1'b0;
    repeat (3) @(negedge clk);

    // chip-select mode: wait while high, then run
    cfg_cs_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7", "oe float with cs high", {sck_oe, sdo_oe}, 2'b00);
    write_byte(8'h3C);
    moves = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sck_out !== 1'b0) moves++;
    end
    chk("R8", "clock frozen with cs high", moves, 0);
    chk("R8", "no completion with cs high", done, 0);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7", "oe not yet on", {sck_oe, sdo_oe}, 2'b00);
    @(negedge clk);
    chk("R7", "oe on third edge", {sck_oe, sdo_oe}, 2'b11);
    run_rises(8'hA1, 8, 0, cap, t1, t2);
    chk("R8", "sent after wait", cap, 8'h3C);
    chk("R8", "received after wait", rx_data, 8'hA1);
    @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7", "oe float after cs rise", {sck_oe, sdo_oe}, 2'b00);

    // abort by chip-select rise
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    write_byte(8'hE7);
    run_rises(8'h18, 3, 0, cap, t1, t2);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9", "no done after abort", done, 0);
    chk("R9", "rx kept after abort", rx_data, 8'hA1);
    chk("R9", "sck parked high", sck_out, 1);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    write_byte(8'h4B);
    run_rises(8'hB4, 8, 0, cap, t1, t2);
    chk("R9", "restart from MSB", cap, 8'h4B);
    chk("R9", "received after abort", rx_data, 8'hB4);
    chk("R9", "done after restart", done, 1);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule